// File: doc/BRIEF.md
# Power Control and Reset Register Unit

This block is a small I/O-port register unit that a processor reaches with byte and word port accesses. It decodes three ports. The first is a one-byte reset control register that raises a system reset request when its reset bit is newly set. The second is a 16-bit sleep control register that holds a sleep type and carries the power-management interrupt enable in its lowest bit. Writing that register with the sleep-enable bit set and sleep type 5 requests a soft power-off. The third is a write-only one-byte command port that switches the interrupt enable on or off.

Each access is a single-cycle strobe (read or write) carrying an address, a byte count and write data. Read data and the access-error flag are combinational and valid in the same cycle as the strobe. The reset and power-off requests are registered one-cycle pulses that appear in the cycle after the write. The interrupt enable is a registered level that feeds the event logic. The bus has no back-pressure: every strobe completes in its own cycle, so no valid/ready pair is used. Only one strobe is expected per cycle.

Top module: `pwr_rstctl_unit`

## Requirements
- R1: The reset control register at RST_ADDR accepts only one-byte accesses (bus_size = 1). Any other size raises bus_err in the strobe cycle, reads return 0, and writes leave the register unchanged.
- R2: A one-byte read of the reset control register returns in bus_rdata[7:0] the last byte written to it, with bus_rdata[15:8] = 0.
- R3: A write to the reset control register whose bit 2 is 1 while the stored bit 2 is 0 makes sys_rst_req high for exactly the one cycle after the write. This holds whatever the value of bit 1 (hard or soft type). A write with bit 2 set while the stored bit 2 is already 1 gives no pulse.
- R4: The sleep control register at CTL_ADDR accepts only two-byte accesses (bus_size = 2). Other sizes raise bus_err, reads return 0, and writes change nothing.
- R5: A write to the sleep control register stores write-data bits 12:2 and discards bits 15, 14, 13 and 1. On a read, bits 15, 14, 13 and 1 are always 0 and bits 12:2 return the stored value.
- R6: Bit 0 of the sleep control register reads the interrupt enable (sci_en). No write to the sleep control register ever changes it.
- R7: A write to the sleep control register with bit 13 = 1 and bits 12:10 = OFF_TYPE (default 5) makes soft_off_req high for the one cycle after the write, and it does so again on every later qualifying write. If bit 13 is 0 or the type differs, there is no pulse.
- R8: A one-byte write of CMD_ON to CMD_ADDR sets sci_en from the next cycle on, and a write of CMD_OFF clears it. Any other command byte leaves sci_en unchanged.
- R9: The command port is write-only. A read of it returns 0 and raises bus_err. A write with a size other than one byte raises bus_err and is ignored.
- R10: After reset, sci_en, sys_rst_req and soft_off_req are 0, and both registers read 0.
- R11: An access to an address that none of the three ports decodes returns 0 and does not raise bus_err. bus_err is never high without a strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Port address of the access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_size | input | 3 | Access size in bytes (1, 2 or 4) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid in the strobe cycle |
| bus_err | output | 1 | Access rejected, valid in the strobe cycle |
| sys_rst_req | output | 1 | One-cycle system reset request |
| soft_off_req | output | 1 | One-cycle soft power-off request |
| sci_en | output | 1 | Interrupt enable level to the event logic |

## Verification
The bench builds the unit with the sleep control register moved to 16'h1804 and the command port moved to 16'h00B0. The command values and the off type keep their defaults. Because the addresses differ from the defaults, a decoder that ignores its address parameters misses every sleep-register and command access, and the bench sees this at once. The command bytes 0xA0 and 0xA1, the neighbour byte 0xA2 and a sleep type one away from 5 are used to show that the compares match exact values.

// File: rtl/pwr_rstctl_pkg.sv
package pwr_rstctl_pkg;
  localparam int DATA_W   = 16;
  localparam int SIZE_W   = 3;
  localparam int BYTE_W   = 8;
  localparam int TYPE_LSB = 10;
  localparam int TYPE_W   = 3;
  localparam int SLPEN_BIT = 13;
  localparam int RSTGO_BIT = 2;
  localparam int FLD_LSB  = 2;
  localparam int FLD_MSB  = 12;
  localparam int FLD_W    = FLD_MSB - FLD_LSB + 1;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_RST  = 2'd1,
    SEL_CTL  = 2'd2,
    SEL_CMD  = 2'd3
  } pwr_sel_e;

  typedef struct packed {
    logic wr_rst;
    logic wr_ctl;
    logic wr_cmd;
    logic rd_rst;
    logic rd_ctl;
  } pwr_acc_t;
endpackage

// File: rtl/pwr_decode.sv
module pwr_decode
  import pwr_rstctl_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] RST_ADDR = 16'h0CF9,
  parameter logic [ADDR_W-1:0] CTL_ADDR = 16'h0404,
  parameter logic [ADDR_W-1:0] CMD_ADDR = 16'h00B2
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  input  logic [SIZE_W-1:0] size,
  output pwr_acc_t          acc,
  output logic              err
);
  localparam logic [SIZE_W-1:0] SZ_BYTE = SIZE_W'(1);
  localparam logic [SIZE_W-1:0] SZ_WORD = SIZE_W'(2);

  pwr_sel_e sel;
  logic     size_ok;

  always_comb begin
    if (addr == RST_ADDR)      sel = SEL_RST;
    else if (addr == CTL_ADDR) sel = SEL_CTL;
    else if (addr == CMD_ADDR) sel = SEL_CMD;
    else                       sel = SEL_NONE;
  end

  always_comb begin
    case (sel)
      SEL_RST: size_ok = (size == SZ_BYTE);
      SEL_CTL: size_ok = (size == SZ_WORD);
      SEL_CMD: size_ok = (size == SZ_BYTE);
      default: size_ok = 1'b0;
    endcase
  end

  always_comb begin
    acc        = '0;
    acc.wr_rst = wr && size_ok && (sel == SEL_RST);
    acc.wr_ctl = wr && size_ok && (sel == SEL_CTL);
    acc.wr_cmd = wr && size_ok && (sel == SEL_CMD);
    acc.rd_rst = rd && size_ok && (sel == SEL_RST);
    acc.rd_ctl = rd && size_ok && (sel == SEL_CTL);
  end

  always_comb begin
    err = 1'b0;
    if (sel != SEL_NONE) begin
      if ((rd || wr) && !size_ok) err = 1'b1;
      if (rd && (sel == SEL_CMD)) err = 1'b1;
    end
  end
endmodule

// File: rtl/pwr_rst_reg.sv
module pwr_rst_reg
  import pwr_rstctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wbyte,
  output logic [BYTE_W-1:0] rbyte,
  output logic              rst_pulse
);
  logic [BYTE_W-1:0] byte_q;
  logic              go_rise;

  // Bit 1 (hard/soft) is kept for read-back only; both kinds request the same reset.
  assign go_rise = wr_en && wbyte[RSTGO_BIT] && !byte_q[RSTGO_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_q    <= '0;
      rst_pulse <= 1'b0;
    end else begin
      rst_pulse <= go_rise;
      if (wr_en) byte_q <= wbyte;
    end
  end

  assign rbyte = byte_q;
endmodule

// File: rtl/pwr_cmd_dec.sv
module pwr_cmd_dec
  import pwr_rstctl_pkg::*;
#(
  parameter logic [BYTE_W-1:0] CMD_ON  = 8'hA0,
  parameter logic [BYTE_W-1:0] CMD_OFF = 8'hA1
) (
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] cmd,
  output logic              ie_set,
  output logic              ie_clr
);
  assign ie_set = wr_en && (cmd == CMD_ON);
  assign ie_clr = wr_en && (cmd == CMD_OFF);
endmodule

// File: rtl/pwr_slp_reg.sv
module pwr_slp_reg
  import pwr_rstctl_pkg::*;
#(
  parameter logic [TYPE_W-1:0] OFF_TYPE = 3'd5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic              ie_set,
  input  logic              ie_clr,
  output logic [DATA_W-1:0] rdata,
  output logic              ie,
  output logic              off_pulse
);
  logic [FLD_W-1:0] fld_q;
  logic             ie_q;
  logic             off_hit;

  // The decision uses the type carried by this same write.
  assign off_hit = wr_en && wdata[SLPEN_BIT] &&
                   (wdata[TYPE_LSB +: TYPE_W] == OFF_TYPE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fld_q     <= '0;
      off_pulse <= 1'b0;
    end else begin
      off_pulse <= off_hit;
      if (wr_en) fld_q <= wdata[FLD_MSB:FLD_LSB];
    end
  end

  // Only the command port moves the enable; this register's write path never does.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ie_q <= 1'b0;
    else if (ie_set) ie_q <= 1'b1;
    else if (ie_clr) ie_q <= 1'b0;
  end

  always_comb begin
    rdata                  = '0;
    rdata[FLD_MSB:FLD_LSB] = fld_q;
    rdata[0]               = ie_q;
  end

  assign ie = ie_q;
endmodule

// File: rtl/pwr_rstctl_unit.sv
module pwr_rstctl_unit
  import pwr_rstctl_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] RST_ADDR = 16'h0CF9,
  parameter logic [ADDR_W-1:0] CTL_ADDR = 16'h0404,
  parameter logic [ADDR_W-1:0] CMD_ADDR = 16'h00B2,
  parameter logic [7:0] CMD_ON  = 8'hA0,
  parameter logic [7:0] CMD_OFF = 8'hA1,
  parameter logic [2:0] OFF_TYPE = 3'd5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [2:0]        bus_size,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  output logic              bus_err,
  output logic              sys_rst_req,
  output logic              soft_off_req,
  output logic              sci_en
);
  pwr_acc_t          acc;
  logic [BYTE_W-1:0] rst_byte;
  logic [DATA_W-1:0] ctl_word;
  logic              ie_set, ie_clr;

  pwr_decode #(
    .ADDR_W(ADDR_W), .RST_ADDR(RST_ADDR), .CTL_ADDR(CTL_ADDR), .CMD_ADDR(CMD_ADDR)
  ) u_dec (
    .addr(bus_addr), .rd(bus_rd), .wr(bus_wr), .size(bus_size),
    .acc(acc), .err(bus_err)
  );

  pwr_rst_reg u_rst (
    .clk(clk), .rst_n(rst_n), .wr_en(acc.wr_rst),
    .wbyte(bus_wdata[BYTE_W-1:0]), .rbyte(rst_byte), .rst_pulse(sys_rst_req)
  );

  pwr_cmd_dec #(.CMD_ON(CMD_ON), .CMD_OFF(CMD_OFF)) u_cmd (
    .wr_en(acc.wr_cmd), .cmd(bus_wdata[BYTE_W-1:0]),
    .ie_set(ie_set), .ie_clr(ie_clr)
  );

  pwr_slp_reg #(.OFF_TYPE(OFF_TYPE)) u_slp (
    .clk(clk), .rst_n(rst_n), .wr_en(acc.wr_ctl), .wdata(bus_wdata),
    .ie_set(ie_set), .ie_clr(ie_clr), .rdata(ctl_word),
    .ie(sci_en), .off_pulse(soft_off_req)
  );

  always_comb begin
    bus_rdata = '0;
    if (acc.rd_rst)      bus_rdata = {{(DATA_W-BYTE_W){1'b0}}, rst_byte};
    else if (acc.rd_ctl) bus_rdata = ctl_word;
  end
endmodule

// File: rtl/pwr_rstctl_chk.sv
module pwr_rstctl_chk #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] RST_ADDR = 16'h0CF9,
  parameter logic [ADDR_W-1:0] CTL_ADDR = 16'h0404,
  parameter logic [ADDR_W-1:0] CMD_ADDR = 16'h00B2,
  parameter logic [2:0] OFF_TYPE = 3'd5
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic [2:0]        bus_size,
  input logic [15:0]       bus_wdata,
  input logic [15:0]       bus_rdata,
  input logic              bus_err,
  input logic              sys_rst_req,
  input logic              soft_off_req,
  input logic              sci_en
);
  assert_rst_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req |-> $past(bus_wr && bus_addr == RST_ADDR && bus_size == 3'd1 && bus_wdata[2]));

  assert_rst_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req |=> !sys_rst_req);

  assert_off_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    soft_off_req |-> $past(bus_wr && bus_addr == CTL_ADDR && bus_size == 3'd2 &&
                           bus_wdata[13] && bus_wdata[12:10] == OFF_TYPE));

  assert_ie_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == CMD_ADDR) |=> $stable(sci_en));

  assert_ctl_zero_bits_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == CTL_ADDR && bus_size == 3'd2) |->
      (bus_rdata[15:13] == 3'b000 && bus_rdata[1] == 1'b0 && bus_rdata[0] == sci_en));

  assert_err_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> (bus_rd || bus_wr));

  assert_cmd_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == CMD_ADDR) |-> (bus_err && bus_rdata == 16'h0000));
endmodule

bind pwr_rstctl_unit pwr_rstctl_chk #(
  .ADDR_W(ADDR_W), .RST_ADDR(RST_ADDR), .CTL_ADDR(CTL_ADDR),
  .CMD_ADDR(CMD_ADDR), .OFF_TYPE(OFF_TYPE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
  .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err),
  .sys_rst_req(sys_rst_req), .soft_off_req(soft_off_req), .sci_en(sci_en)
);

// File: tb/tb_pwr_rstctl_unit.sv
module tb_pwr_rstctl_unit;
  localparam logic [15:0] RST_A = 16'h0CF9;
  localparam logic [15:0] CTL_A = 16'h1804;
  localparam logic [15:0] CMD_A = 16'h00B0;
  localparam logic [15:0] NONE_A = 16'h0400;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bus_addr = '0;
  logic        bus_rd = 1'b0, bus_wr = 1'b0;
  logic [2:0]  bus_size = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        bus_err, sys_rst_req, soft_off_req, sci_en;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pwr_rstctl_unit #(.CTL_ADDR(CTL_A), .CMD_ADDR(CMD_A)) dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err),
    .sys_rst_req(sys_rst_req), .soft_off_req(soft_off_req), .sci_en(sci_en)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive at negedge, sample err before the edge, sample pulses/enable after it.
  task automatic wr(input logic [15:0] a, input logic [2:0] sz, input logic [15:0] d,
                    output bit e, output bit rq, output bit off, output bit ie);
    @(negedge clk);
    bus_addr = a; bus_size = sz; bus_wdata = d; bus_wr = 1'b1;
    #1 e = bus_err;
    @(posedge clk); #1;
    rq = sys_rst_req; off = soft_off_req; ie = sci_en;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, input logic [2:0] sz,
                    output logic [15:0] q, output bit e);
    @(negedge clk);
    bus_addr = a; bus_size = sz; bus_rd = 1'b1;
    #1 q = bus_rdata; e = bus_err;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic t_reset_state();
    logic [15:0] q; bit e;
    check(!sci_en && !sys_rst_req && !soft_off_req, "R10 outputs",
          {sci_en, sys_rst_req, soft_off_req}, 0);
    rd(RST_A, 3'd1, q, e); check(q == 0 && !e, "R10 rst reg", q, 0);
    rd(CTL_A, 3'd2, q, e); check(q == 0 && !e, "R10 ctl reg", q, 0);
  endtask

  task automatic t_reset_reg();
    logic [15:0] q; bit e, rq, off, ie;
    wr(RST_A, 3'd1, 16'h00_02, e, rq, off, ie);
    check(!rq && !e, "R3 bit1 alone no pulse", rq, 0);
    rd(RST_A, 3'd1, q, e); check(q == 16'h0002, "R2 readback", q, 16'h0002);
    wr(RST_A, 3'd1, 16'h0006, e, rq, off, ie);
    check(rq, "R3 hard rise pulse", rq, 1);
    @(negedge clk); #1 check(!sys_rst_req, "R3 pulse one cycle", sys_rst_req, 0);
    wr(RST_A, 3'd1, 16'h0004, e, rq, off, ie);
    check(!rq, "R3 no pulse when already set", rq, 0);
    wr(RST_A, 3'd1, 16'h0000, e, rq, off, ie);
    wr(RST_A, 3'd1, 16'h0004, e, rq, off, ie);
    check(rq, "R3 soft rise pulse", rq, 1);
    wr(RST_A, 3'd2, 16'h00F0, e, rq, off, ie);
    check(e, "R1 word write err", e, 1);
    rd(RST_A, 3'd1, q, e); check(q == 16'h0004, "R1 word write ignored", q, 16'h0004);
    rd(RST_A, 3'd2, q, e); check(e && q == 0, "R1 word read err", q, 0);
    wr(RST_A, 3'd1, 16'hAB5A, e, rq, off, ie);
    rd(RST_A, 3'd1, q, e); check(q == 16'h005A, "R2 byte readback", q, 16'h005A);
  endtask

  task automatic t_command();
    logic [15:0] q; bit e, rq, off, ie;
    wr(CMD_A, 3'd1, 16'h00A0, e, rq, off, ie);
    check(ie && !e, "R8 enable cmd", ie, 1);
    wr(CMD_A, 3'd1, 16'h00A2, e, rq, off, ie);
    check(ie, "R8 unknown cmd ignored", ie, 1);
    wr(CMD_A, 3'd2, 16'h00A1, e, rq, off, ie);
    check(e && ie, "R9 wrong size cmd ignored", {e, ie}, 3);
    rd(CMD_A, 3'd1, q, e); check(e && q == 0, "R9 cmd read", q, 0);
    rd(CTL_A, 3'd2, q, e); check(q[0], "R6 bit0 shows enable", q, 1);
    wr(CTL_A, 3'd2, 16'h0000, e, rq, off, ie);
    check(ie, "R6 ctl write keeps enable", ie, 1);
    wr(CMD_A, 3'd1, 16'h00A1, e, rq, off, ie);
    check(!ie, "R8 disable cmd", ie, 0);
    wr(CTL_A, 3'd2, 16'hFFFF, e, rq, off, ie);
    check(!ie, "R6 ctl write cannot set enable", ie, 0);
  endtask

  task automatic t_sleep();
    logic [15:0] q; bit e, rq, off, ie;
    wr(CTL_A, 3'd2, 16'hFFFF, e, rq, off, ie);
    check(!off, "R7 type 7 no off", off, 0);
    rd(CTL_A, 3'd2, q, e); check(q == 16'h1FFC, "R5 masked store", q, 16'h1FFC);
    wr(CTL_A, 3'd2, 16'h1400, e, rq, off, ie);
    check(!off, "R7 no enable no off", off, 0);
    rd(CTL_A, 3'd2, q, e); check(q == 16'h1400, "R5 type stored", q, 16'h1400);
    wr(CTL_A, 3'd2, 16'h3400, e, rq, off, ie);
    check(off, "R7 off pulse", off, 1);
    @(negedge clk); #1 check(!soft_off_req, "R7 off one cycle", soft_off_req, 0);
    rd(CTL_A, 3'd2, q, e); check(q == 16'h1400, "R5 bit13 reads 0", q, 16'h1400);
    wr(CTL_A, 3'd2, 16'h3400, e, rq, off, ie);
    check(off, "R7 second off pulse", off, 1);
    wr(CTL_A, 3'd2, 16'h3000, e, rq, off, ie);
    check(!off, "R7 type 4 no off", off, 0);
    wr(CTL_A, 3'd1, 16'h3400, e, rq, off, ie);
    check(e && !off, "R4 byte write err", {e, off}, 2);
    rd(CTL_A, 3'd2, q, e); check(q == 16'h1000, "R4 byte write ignored", q, 16'h1000);
    rd(CTL_A, 3'd4, q, e); check(e && q == 0, "R4 dword read err", q, 0);
  endtask

  task automatic t_unmapped();
    logic [15:0] q; bit e, rq, off, ie;
    rd(NONE_A, 3'd2, q, e); check(!e && q == 0, "R11 unmapped read", q, 0);
    wr(NONE_A, 3'd1, 16'h00A0, e, rq, off, ie);
    check(!e && !ie, "R11 unmapped write", {e, ie}, 0);
    @(negedge clk); #1 check(!bus_err, "R11 idle no err", bus_err, 0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_reset_reg();
        t_command();
        t_sleep();
        t_unmapped();
        done = 1'b1;
      end
      begin
        repeat (5000) @(posedge clk);
        if (!done) check(1'b0, "watchdog", 0, 1);
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule